// File: doc/BRIEF.md
# Device Interrupt Router

This block sits between a fixed set of I/O devices and the processor cores. Every device owns two 64-bit registers in two separate banks: a routing register that names the core an interrupt goes to and the vector it carries, and a control register that holds a mask bit and a pending bit. Software programs both banks over a write-only register bus. Inside each bank the device registers sit at an 8-byte stride: the device number is the byte offset from the bank base shifted right by three.

Each device input is edge-detected. When a device input rises and the device is unmasked, the block accepts the interrupt and sets both the mask bit and the pending bit of that device. It then sends a single one-cycle post carrying the stored core number and vector. Because acceptance also sets the mask, each device delivers at most one post until software clears the mask again. When a rising edge arrives from a masked device, the block drops it. When several accepted interrupts wait at the same time, the block drains them lowest device number first, one post per cycle.

A write to an address that lies in neither bank raises a sticky error flag, which only reset clears. The mask and pending bits are also brought out as ports, so the interrupt fabric can see them.

Top module: `irq_router`

## Requirements
- R1: A write to the routing bank (base 0x200, 8 bytes per device, 8 devices) stores data bits 12:8 as the target core and data bits 5:0 as the vector of device (address − 0x200) >> 3; every other data bit is ignored. Any address inside a device's 8-byte slot selects that device.
- R2: A write to the control bank (base 0x400, 8 bytes per device) copies data bit 2 into the mask bit of device (address − 0x400) >> 3.
- R3: In a control write, a 1 in data bit 1 clears the device's pending bit, and a 0 in data bit 1 leaves it as it was.
- R4: A rising device input while that device's mask bit is 1 produces no post and changes neither the mask bit nor the pending bit.
- R5: A rising device input while that device's mask bit is 0 sets both its mask bit and its pending bit at the clock edge that samples the rising input. If a control write to the same device falls on that edge, the acceptance wins.
- R6: Each accepted interrupt produces exactly one post. postValid is high for one cycle, and postCore and postVec carry the device's stored core and vector. With no other requests waiting, the post appears one cycle after acceptance.
- R7: Only a low-to-high transition counts as an interrupt. A device input held high causes no further post, even after software clears the mask while the input stays high.
- R8: When several accepted interrupts are waiting, the lowest device number is posted first, one post per cycle on consecutive cycles.
- R9: A write whose address falls in neither bank sets errFlag. errFlag stays 1 through later valid writes until reset.
- R10: Reset (rstN low) clears all mask bits, pending bits, core fields, vector fields, waiting requests, postValid and errFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 16 | Byte address of the write |
| wrData | input | 64 | Write data |
| devIrq | input | 8 | Device interrupt inputs, one per device |
| postValid | output | 1 | One-cycle post strobe |
| postCore | output | 5 | Target core of the post |
| postVec | output | 6 | Vector of the post |
| maskBits | output | 8 | Per-device mask bits |
| pendBits | output | 8 | Per-device pending bits |
| errFlag | output | 1 | Sticky flag for unmapped writes |

## Verification
The assertions assume that wrEn, wrAddr, wrData and devIrq are stable around the sampling edge. They also assume that a device input counts only through its own rising edge, so a level that stays high must not look like a fresh request. The stimulus changes every input only at the falling clock edge and returns each device input low before raising it again, except in the held-level case, which tests R7 on purpose. Control writes and device edges for the same device are kept on separate cycles, except where the bench checks how the two interact.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Strobes that the control half hands to the datapath each cycle.
  typedef struct packed {
    logic manWr;    // write to the routing bank
    logic ctlWr;    // write to the control bank
    logic errSet;   // write hit no bank
    logic postFire; // a waiting request is granted this cycle
  } strobes_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int          NUM_DEV  = 8,
  parameter int          ADDR_W   = 16,
  parameter int          IDX_W    = 3,
  parameter int unsigned MAN_BASE = 'h200,
  parameter int unsigned CTL_BASE = 'h400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_DEV-1:0] devIrq,
  input  logic [NUM_DEV-1:0] maskBits,
  output strobes_t           strb,
  output logic [IDX_W-1:0]   wrIdx,
  output logic [IDX_W-1:0]   postIdx,
  output logic [NUM_DEV-1:0] acceptVec
);

  localparam int unsigned   BANK_BYTES = NUM_DEV * 8;
  localparam logic [ADDR_W:0] MAN_LO = (ADDR_W+1)'(MAN_BASE);
  localparam logic [ADDR_W:0] MAN_HI = (ADDR_W+1)'(MAN_BASE + BANK_BYTES);
  localparam logic [ADDR_W:0] CTL_LO = (ADDR_W+1)'(CTL_BASE);
  localparam logic [ADDR_W:0] CTL_HI = (ADDR_W+1)'(CTL_BASE + BANK_BYTES);

  // ---------------- address decode ----------------
  logic [ADDR_W:0] addrX;
  logic [ADDR_W:0] manOff;
  logic [ADDR_W:0] ctlOff;
  logic            manHit;
  logic            ctlHit;

  assign addrX  = {1'b0, wrAddr};
  assign manOff = addrX - MAN_LO;
  assign ctlOff = addrX - CTL_LO;
  assign manHit = wrEn && (addrX >= MAN_LO) && (addrX < MAN_HI);
  assign ctlHit = wrEn && (addrX >= CTL_LO) && (addrX < CTL_HI);
  assign wrIdx  = manHit ? IDX_W'(manOff >> 3) : IDX_W'(ctlOff >> 3);

  // ---------------- edge detection ----------------
  logic [NUM_DEV-1:0] irqPrev;
  logic [NUM_DEV-1:0] edgeVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= devIrq;
  end

  assign edgeVec   = devIrq & ~irqPrev;
  assign acceptVec = edgeVec & ~maskBits;

  // ---------------- request queue and arbiter ----------------
  logic [NUM_DEV-1:0] reqQ;
  logic [NUM_DEV-1:0] grantVec;
  logic               found;
  logic [IDX_W-1:0]   pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (reqQ[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  assign grantVec = found ? (NUM_DEV'(1) << pick) : '0;
  assign postIdx  = pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= (reqQ & ~grantVec) | acceptVec;
  end

  always_comb begin
    strb.manWr    = manHit;
    strb.ctlWr    = ctlHit;
    strb.errSet   = wrEn && !manHit && !ctlHit;
    strb.postFire = found;
  end

  // ---------------- assertions ----------------
  p_grant_waiting_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.postFire |-> reqQ[postIdx]);

  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.postFire |-> ((reqQ & ((NUM_DEV'(1) << postIdx) - NUM_DEV'(1))) == '0));

  p_waiting_served_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqQ != '0) |-> strb.postFire);

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IDX_W   = 3,
  parameter int CORE_W  = 5,
  parameter int VEC_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [IDX_W-1:0]   postIdx,
  input  logic [NUM_DEV-1:0] acceptVec,
  input  logic [63:0]        wrData,
  output logic [NUM_DEV-1:0] maskBits,
  output logic [NUM_DEV-1:0] pendBits,
  output logic               postValid,
  output logic [CORE_W-1:0]  postCore,
  output logic [VEC_W-1:0]   postVec,
  output logic               errFlag
);

  localparam int CORE_LSB = 8;
  localparam int VEC_LSB  = 0;
  localparam int MASK_BIT = 2;
  localparam int CLR_BIT  = 1;

  logic [CORE_W-1:0] coreR [NUM_DEV];
  logic [VEC_W-1:0]  vecR  [NUM_DEV];
  logic [NUM_DEV-1:0] maskR;
  logic [NUM_DEV-1:0] pendR;
  logic               unusedData;

  assign unusedData = ^wrData;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    logic selMan;
    logic selCtl;
    assign selMan = strb.manWr && (wrIdx == IDX_W'(g));
    assign selCtl = strb.ctlWr && (wrIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coreR[g] <= '0;
        vecR[g]  <= '0;
      end else if (selMan) begin
        coreR[g] <= wrData[CORE_LSB +: CORE_W];
        vecR[g]  <= wrData[VEC_LSB +: VEC_W];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR[g] <= 1'b0;
        pendR[g] <= 1'b0;
      end else if (acceptVec[g]) begin
        maskR[g] <= 1'b1;
        pendR[g] <= 1'b1;
      end else if (selCtl) begin
        maskR[g] <= wrData[MASK_BIT];
        if (wrData[CLR_BIT]) pendR[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postValid <= 1'b0;
      postCore  <= '0;
      postVec   <= '0;
    end else begin
      postValid <= strb.postFire;
      if (strb.postFire) begin
        postCore <= coreR[postIdx];
        postVec  <= vecR[postIdx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (strb.errSet) errFlag <= 1'b1;
  end

  assign maskBits = maskR;
  assign pendBits = pendR;

  // ---------------- assertions ----------------
  p_accept_sets_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (acceptVec != '0) |=> ((maskR & $past(acceptVec)) == $past(acceptVec)));

  p_pend_rise_needs_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((pendR & ~$past(pendR) & ~$past(acceptVec)) == '0));

  p_post_follows_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    postValid |-> $past(strb.postFire));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
#(
  parameter int          NUM_DEV  = 8,
  parameter int          ADDR_W   = 16,
  parameter int          CORE_W   = 5,
  parameter int          VEC_W    = 6,
  parameter int unsigned MAN_BASE = 'h200,
  parameter int unsigned CTL_BASE = 'h400
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [63:0]        wrData,
  input  logic [NUM_DEV-1:0] devIrq,
  output logic               postValid,
  output logic [CORE_W-1:0]  postCore,
  output logic [VEC_W-1:0]   postVec,
  output logic [NUM_DEV-1:0] maskBits,
  output logic [NUM_DEV-1:0] pendBits,
  output logic               errFlag
);

  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  strobes_t           strb;
  logic [IDX_W-1:0]   wrIdx;
  logic [IDX_W-1:0]   postIdx;
  logic [NUM_DEV-1:0] acceptVec;

  irq_route_ctrl #(
    .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .MAN_BASE(MAN_BASE), .CTL_BASE(CTL_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .devIrq(devIrq), .maskBits(maskBits), .strb(strb),
    .wrIdx(wrIdx), .postIdx(postIdx), .acceptVec(acceptVec)
  );

  irq_route_dp #(
    .NUM_DEV(NUM_DEV), .IDX_W(IDX_W), .CORE_W(CORE_W), .VEC_W(VEC_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx),
    .postIdx(postIdx), .acceptVec(acceptVec), .wrData(wrData),
    .maskBits(maskBits), .pendBits(pendBits), .postValid(postValid),
    .postCore(postCore), .postVec(postVec), .errFlag(errFlag)
  );

endmodule

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;

  localparam int ND = 8;
  localparam int MAN = 'h200;
  localparam int CTL = 'h400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [7:0]  devIrq = '0;
  logic        postValid;
  logic [4:0]  postCore;
  logic [5:0]  postVec;
  logic [7:0]  maskBits;
  logic [7:0]  pendBits;
  logic        errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .devIrq(devIrq), .postValid(postValid), .postCore(postCore),
    .postVec(postVec), .maskBits(maskBits), .pendBits(pendBits),
    .errFlag(errFlag)
  );

  // ---------------- behavioural reference model ----------------
  bit  mMask [ND];
  bit  mPend [ND];
  bit  mReq  [ND];
  bit  mPrev [ND];
  int  mCore [ND];
  int  mVec  [ND];
  bit  mErr, mPostV;
  int  mPostC, mPostVec;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ND; i++) begin
        mMask[i] = 0; mPend[i] = 0; mReq[i] = 0; mPrev[i] = 0;
        mCore[i] = 0; mVec[i] = 0;
      end
      mErr = 0; mPostV = 0; mPostC = 0; mPostVec = 0;
    end else begin
      int  a, sel;
      bit  oldMask [ND];
      bit  hitM, hitC;
      sel = -1;
      for (int i = ND - 1; i >= 0; i--) if (mReq[i]) sel = i;
      mPostV = (sel >= 0);
      if (sel >= 0) begin
        mPostC = mCore[sel]; mPostVec = mVec[sel]; mReq[sel] = 0;
      end
      for (int i = 0; i < ND; i++) oldMask[i] = mMask[i];
      a = int'(wrAddr);
      hitM = wrEn && a >= MAN && a < MAN + ND * 8;
      hitC = wrEn && a >= CTL && a < CTL + ND * 8;
      if (hitM) begin
        mCore[(a - MAN) / 8] = int'(wrData[12:8]);
        mVec[(a - MAN) / 8]  = int'(wrData[5:0]);
      end
      if (hitC) begin
        mMask[(a - CTL) / 8] = wrData[2];
        if (wrData[1]) mPend[(a - CTL) / 8] = 0;
      end
      if (wrEn && !hitM && !hitC) mErr = 1;
      for (int i = 0; i < ND; i++) begin
        if (devIrq[i] && !mPrev[i] && !oldMask[i]) begin
          mMask[i] = 1; mPend[i] = 1; mReq[i] = 1;
        end
        mPrev[i] = devIrq[i];
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] packBits(input bit v [ND]);
    logic [7:0] r;
    for (int i = 0; i < ND; i++) r[i] = v[i];
    return r;
  endfunction

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R5 maskBits vs model", {56'd0, maskBits}, {56'd0, packBits(mMask)});
      check("R3/R5 pendBits vs model", {56'd0, pendBits}, {56'd0, packBits(mPend)});
      check("R6 postValid vs model", {63'd0, postValid}, {63'd0, mPostV});
      if (mPostV) begin
        check("R1 postCore vs model", {59'd0, postCore}, 64'(mPostC));
        check("R1 postVec vs model", {58'd0, postVec}, 64'(mPostVec));
      end
      check("R9 errFlag vs model", {63'd0, errFlag}, {63'd0, mErr});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int addr, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expPost(string tag, int core, int vec);
    check({tag, " postValid"}, {63'd0, postValid}, 64'd1);
    check({tag, " postCore"}, {59'd0, postCore}, 64'(core));
    check({tag, " postVec"}, {58'd0, postVec}, 64'(vec));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    check("R10 maskBits at reset", {56'd0, maskBits}, 64'd0);
    check("R10 pendBits at reset", {56'd0, pendBits}, 64'd0);
    check("R10 postValid at reset", {63'd0, postValid}, 64'd0);
    check("R10 errFlag at reset", {63'd0, errFlag}, 64'd0);
    rstN = 1'b1;
    tick();

    // R1 / R5 / R6: route device 3, junk in unused data bits
    wr(MAN + 3 * 8, 64'hFFFF_0000_0000_00C0 | (64'd5 << 8) | 64'h2A);
    @(negedge clk); devIrq[3] = 1'b1;
    tick();
    check("R5 mask set on accept", {63'd0, maskBits[3]}, 64'd1);
    check("R5 pend set on accept", {63'd0, pendBits[3]}, 64'd1);
    devIrq[3] = 1'b0;
    tick();
    expPost("R1 R6 dev3", 5, 'h2A);
    tick();
    check("R6 single-cycle post", {63'd0, postValid}, 64'd0);

    // R3: bit1=0 leaves pending, bit1=1 clears it
    wr(CTL + 3 * 8, 64'h4);
    check("R3 pend kept with bit1=0", {63'd0, pendBits[3]}, 64'd1);
    wr(CTL + 3 * 8 + 5, 64'h6);
    check("R3 pend cleared with bit1=1", {63'd0, pendBits[3]}, 64'd0);
    check("R2 mask written from bit2", {63'd0, maskBits[3]}, 64'd1);

    // R4: edge on a masked device is dropped
    @(negedge clk); devIrq[3] = 1'b1;
    tick(); devIrq[3] = 1'b0;
    tick();
    check("R4 no post from masked device", {63'd0, postValid}, 64'd0);
    check("R4 pend untouched", {63'd0, pendBits[3]}, 64'd0);
    check("R4 mask untouched", {63'd0, maskBits[3]}, 64'd1);

    // R2: mask from the last slot of the control bank, device 7
    wr(CTL + 7 * 8, 64'h4);
    check("R2 mask dev7 set", {56'd0, maskBits}, 64'h88);
    @(negedge clk); devIrq[7] = 1'b1;
    tick(); devIrq[7] = 1'b0;
    tick();
    check("R2 R4 dev7 masked no post", {63'd0, postValid}, 64'd0);
    wr(CTL + 3 * 8, 64'h0);
    check("R2 mask dev3 cleared", {56'd0, maskBits}, 64'h80);

    // R7: held level produces one post only
    wr(MAN + 5 * 8, (64'd7 << 8) | 64'h05);
    @(negedge clk); devIrq[5] = 1'b1;
    tick();
    tick();
    expPost("R7 dev5 first", 7, 5);
    wr(CTL + 5 * 8, 64'h2);
    check("R7 mask dev5 cleared", {63'd0, maskBits[5]}, 64'd0);
    tick();
    tick();
    check("R7 held level no repost", {63'd0, postValid}, 64'd0);
    check("R7 held level mask stays 0", {63'd0, maskBits[5]}, 64'd0);
    devIrq[5] = 1'b0;
    tick(); devIrq[5] = 1'b1;
    tick(); devIrq[5] = 1'b0;
    tick();
    expPost("R7 dev5 after new edge", 7, 5);

    // R8: simultaneous edges drained lowest first
    wr(MAN + 1 * 8, (64'd1 << 8) | 64'h11);
    wr(MAN + 2 * 8, (64'd2 << 8) | 64'h12);
    wr(MAN + 6 * 8, (64'd31 << 8) | 64'h3F);
    @(negedge clk); devIrq = 8'h46;
    tick();
    check("R8 three masks set", {56'd0, maskBits & 8'h46}, 64'h46);
    devIrq = 8'h00;
    tick();
    expPost("R8 first dev1", 1, 'h11);
    tick();
    expPost("R8 second dev2", 2, 'h12);
    tick();
    expPost("R8 third dev6", 31, 'h3F);
    tick();
    check("R8 drain done", {63'd0, postValid}, 64'd0);

    // R5: acceptance wins over a control write on the same edge
    wr(CTL + 1 * 8, 64'h2);
    @(negedge clk);
    devIrq[1] = 1'b1;
    wrEn = 1'b1; wrAddr = 16'(CTL + 1 * 8); wrData = 64'h2;
    tick();
    wrEn = 1'b0; wrAddr = '0; wrData = '0; devIrq[1] = 1'b0;
    check("R5 accept beats write mask", {63'd0, maskBits[1]}, 64'd1);
    check("R5 accept beats write pend", {63'd0, pendBits[1]}, 64'd1);
    tick();
    expPost("R5 dev1 post", 1, 'h11);

    // R9: unmapped writes set a sticky flag
    wr(MAN + ND * 8, 64'h0);
    check("R9 gap address error", {63'd0, errFlag}, 64'd1);
    wr(MAN, 64'h0);
    wr('h0800, 64'h0);
    check("R9 error sticky", {63'd0, errFlag}, 64'd1);

    // R10: reset clears everything again
    @(negedge clk); rstN = 1'b0;
    tick();
    check("R10 errFlag cleared by reset", {63'd0, errFlag}, 64'd0);
    check("R10 masks cleared by reset", {56'd0, maskBits}, 64'd0);
    check("R10 pend cleared by reset", {56'd0, pendBits}, 64'd0);
    rstN = 1'b1;
    @(negedge clk); devIrq[6] = 1'b1;
    tick(); devIrq[6] = 1'b0;
    tick();
    expPost("R10 routing cleared by reset", 0, 0);
    tick();
    finishRun();
  end

endmodule